// File: doc/BRIEF.md
# Timer clock source selector

This block produces the count-enable for an 8-bit timer. A 3-bit select code picks one of eight sources: stopped, every system clock, the system clock divided by 8, 64, 256 or 1024, or a falling or rising edge on an external count pin. The result is a single-cycle `tick_o` pulse in the system clock domain. The timer counter advances by one in each cycle where `tick_o` is high.

A free-running prescaler supplies all divided rates. A synchronous prescaler-reset input restarts it, so software can line up the first divided tick with a known cycle. The external pin passes through a two-flop synchronizer and an edge detector. It is sampled whatever its pad direction is, so software that toggles the pin as an output still advances the count. The output tick is registered, so it stays free of glitches when the select code changes.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0.
- R2: With `sel_i` = 3'b000, `tick_o` stays 0 on every clock.
- R3: With `sel_i` = 3'b001, `tick_o` is 1 after every rising clock edge at which 3'b001 was sampled, whatever `pre_rst_i` is.
- R4: With `sel_i` = 3'b010, 3'b011, 3'b100 or 3'b101, `tick_o` is a one-cycle pulse repeating every 8, 64, 256 or 1024 clocks respectively.
- R5: At an edge where `pre_rst_i` is 1 and a divided rate is selected, `tick_o` is 0 after that edge. The divider restarts from zero, so the next divided tick follows exactly N edges later, where N is the selected ratio.
- R6: With `sel_i` = 3'b111, a low-to-high change on `ext_pin_i` gives exactly one tick, on the third clock edge after the change. This allows for two synchronizer flops and the output register. Holding the pin high gives no further ticks.
- R7: With `sel_i` = 3'b110, a high-to-low change on `ext_pin_i` gives exactly one tick, with the same latency as R6. A low-to-high change gives none.
- R8: A new `sel_i` value governs `tick_o` from the very next clock edge. `tick_o` after an edge always reflects the code sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 3 | Clock source select code |
| ext_pin_i | input | 1 | Raw external count pin, asynchronous |
| pre_rst_i | input | 1 | Synchronous prescaler restart |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The bench restarts the prescaler before each divided rate and checks every cycle over three full periods. A tap that decodes the wrong counter bits, or misses a wrap by one, shows up as a misplaced or doubled pulse. It also checks that the tick is masked on the restart edge. A divider that restarts without masking gives a stray pulse, and one that keeps running gives a first tick earlier than N cycles.

External edges are checked at their exact three-edge latency. A pin held at a level for many cycles must give only one tick. The edge of the wrong polarity must give none. A swapped polarity, a missing synchronizer stage or level-sensitive counting each fails one of these checks.

Switching between stopped and undivided shows whether the select code takes effect at the next edge.

// File: rtl/tmr_clk_sel_pkg.sv
package tmr_clk_sel_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } cs_e;

  localparam int unsigned NUM_TAPS = 4;
  // log2 of each divided ratio, in select-code order starting at CS_DIV8
  localparam int unsigned TAP_LOG [NUM_TAPS] = '{3, 6, 8, 10};
  localparam int unsigned PRE_W = TAP_LOG[NUM_TAPS-1];

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_clk_sel_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // a tap fires on the cycle its low bits are about to wrap to zero
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned L = TAP_LOG[i];
    assign tap_o[i] = &cnt_q[L-1:0];
  end

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
  end

  // compare synchronized level with its one-cycle-old copy
  assign rise_o =  chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
  assign fall_o = ~chain_q[CHAIN_W-2] &  chain_q[CHAIN_W-1];

endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux
  import tmr_clk_sel_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cs_e                 sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                tap_mask_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);

  logic tick_d, tick_q;

  always_comb begin
    unique case (sel_i)
      CS_STOP:     tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_DIV8:     tick_d = tap_i[0] & ~tap_mask_i;
      CS_DIV64:    tick_d = tap_i[1] & ~tap_mask_i;
      CS_DIV256:   tick_d = tap_i[2] & ~tap_mask_i;
      CS_DIV1024:  tick_d = tap_i[3] & ~tap_mask_i;
      CS_EXT_FALL: tick_d = fall_i;
      CS_EXT_RISE: tick_d = rise_i;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_sel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_pin_i,
  input  logic       pre_rst_i,
  output logic       tick_o
);

  logic [NUM_TAPS-1:0] tap;
  logic                rise, fall;

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_rst_i),
    .tap_o  (tap)
  );

  tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_tick_mux u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (cs_e'(sel_i)),
    .tap_i      (tap),
    .tap_mask_i (pre_rst_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .tick_o     (tick_o)
  );

endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       pre_rst_i,
  input logic       tick_o
);

  always @(negedge clk_i)
    if (!rst_ni) p_reset_idle_r1: assert (!tick_o);

  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sel_i) == 3'b000) |-> !tick_o);

  p_div1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sel_i) == 3'b001) |-> tick_o);

  p_div_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i inside {3'b010, 3'b011, 3'b100, 3'b101} && $stable(sel_i)) |=> !tick_o);

  p_pre_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(pre_rst_i) &&
     $past(sel_i) inside {3'b010, 3'b011, 3'b100, 3'b101}) |-> !tick_o);

  p_ext_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i[2:1] == 2'b11 && $stable(sel_i)) |=> !tick_o);

endmodule

bind tmr_clk_sel tmr_clk_sel_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .pre_rst_i (pre_rst_i),
  .tick_o    (tick_o)
);

// File: tb/tmr_clk_sel_tb_top.sv
`timescale 1ns/1ps
module tmr_clk_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] sel;
  logic       pin;
  logic       pre_rst;
  logic       tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tmr_clk_sel dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .ext_pin_i (pin),
    .pre_rst_i (pre_rst),
    .tick_o    (tick)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ext edge: expect tick only on step 3 after pin change when exp_tick
  task automatic ext_edge(input bit lvl, input bit exp_tick, input string req);
    pin = lvl;
    for (int k = 1; k <= 8; k++) begin
      step();
      chk(tick, exp_tick && (k == 3), req);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    int cnt;
    rst_ni = 1'b0; sel = 3'b001; pin = 1'b0; pre_rst = 1'b0;
    // R1: reset holds tick low even with undivided select
    for (int k = 0; k < 3; k++) begin
      step();
      chk(tick, 1'b0, "R1");
    end
    rst_ni = 1'b1;
    sel = 3'b000;

    // R2: stopped select over a full slow period
    cnt = 0;
    for (int k = 0; k < 1100; k++) begin
      step();
      cnt += int'(tick);
    end
    chk(cnt == 0, 1'b1, "R2");

    // R3: every clock, including with prescaler restart asserted
    sel = 3'b001;
    for (int k = 0; k < 20; k++) begin
      pre_rst = (k % 3 == 0);
      step();
      chk(tick, 1'b1, "R3");
    end
    pre_rst = 1'b0;

    // R8: select switch acts on the next edge
    sel = 3'b000;
    step();
    chk(tick, 1'b0, "R8");
    sel = 3'b001;
    step();
    chk(tick, 1'b1, "R8");
    sel = 3'b000;
    step();
    chk(tick, 1'b0, "R8");

    // R4/R5: divided rates, aligned by a prescaler restart
    for (int i = 0; i < 4; i++) begin
      int n;
      n = (i == 0) ? 8 : (i == 1) ? 64 : (i == 2) ? 256 : 1024;
      sel = 3'(i + 2);
      pre_rst = 1'b1;
      step();
      chk(tick, 1'b0, "R5");
      pre_rst = 1'b0;
      for (int k = 1; k <= 3 * n; k++) begin
        step();
        chk(tick, (k % n) == 0, (k <= n) ? "R5" : "R4");
      end
    end

    // R5: mid-period restart at ratio 8 pushes the next tick a full period out
    sel = 3'b010;
    pre_rst = 1'b1;
    step();
    pre_rst = 1'b0;
    for (int k = 1; k <= 5; k++) step();
    pre_rst = 1'b1;
    step();
    chk(tick, 1'b0, "R5");
    pre_rst = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      step();
      chk(tick, (k % 8) == 0, "R5");
    end

    // R6: rising edge counting, pin level held long
    sel = 3'b111;
    for (int k = 0; k < 4; k++) step();
    for (int r = 0; r < 3; r++) begin
      ext_edge(1'b1, 1'b1, "R6");
      ext_edge(1'b0, 1'b0, "R6");
    end

    // R7: falling edge counting, rising edge ignored
    sel = 3'b110;
    for (int k = 0; k < 4; k++) step();
    for (int r = 0; r < 3; r++) begin
      ext_edge(1'b1, 1'b0, "R7");
      ext_edge(1'b0, 1'b1, "R7");
    end

    // R2: external edges give nothing while stopped
    sel = 3'b000;
    ext_edge(1'b1, 1'b0, "R2");
    ext_edge(1'b0, 1'b0, "R2");

    summary();
  end

endmodule